// File: doc/BRIEF.md
# Path REI error monitor

This block watches the path status byte of each received SONET payload envelope. The upstream framer marks that byte with a one-cycle strobe. The block decodes the remote error indication field, which is the upper nibble of the byte. Each frame whose field reports a non-zero error count sets an event bit in a shared path interrupt status register. The reported error count is also added to a wide saturating counter.

Software reads the status register and the counter through a simple registered read port. Reading the status register clears it. The counter is read as bytes. Reading the lowest byte takes a coherent snapshot of the whole counter and clears the live count. The other path defect detectors feed their own event pulses into the lower status bits. An active-low interrupt output is asserted while any status bit whose enable is set is pending.

Top module: `path_rei_monitor`

## Requirements
- R1: The error field is bits 7:4 of the status byte. Field values 1 to 8 report that many errors. Values 0 and 9 to 15 report no errors. A byte presented without `g1_stb_i` high is ignored.
- R2: A strobed byte that reports errors sets status bit 6 on the clock edge that samples the strobe.
- R3: Each reported frame adds its error value to a live counter of `CNT_W` bits (32 by default). The counter saturates at all ones and never wraps.
- R4: The status register is at address 0. Bit 6 holds the error event. Bits 5:0 are set by pulses on `path_evt_i[5:0]`. Bit 7 always reads 0.
- R5: Reading address 0 returns the status register and then clears all of its bits. An event arriving in the same cycle as the read stays set.
- R6: Counter bytes are at addresses 1 to `CNT_W/8`, least significant byte first. Reading address 1 returns the live low byte and latches the whole count into a snapshot. The higher addresses return bytes of that snapshot. Unmapped addresses read 0.
- R7: Reading address 1 clears the live counter. An increment arriving in the same cycle is kept as the new count.
- R8: `int_no` is low exactly while some status bit and its bit of `int_en_i` are both 1. A disabled bit still records its event.
- R9: After reset the status register and the counter are 0, `int_no` is high and `rd_data_o` is 0.
- R10: `rd_data_o` updates on the clock edge that samples `rd_en_i`. It holds its value when no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| g1_stb_i | input | 1 | Marks the path status byte |
| g1_byte_i | input | 8 | Path status byte value |
| path_evt_i | input | 6 | Event pulses from the other path detectors, for status bits 5:0 |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 8 | Registered read data |
| int_en_i | input | 7 | Enable for each status bit |
| int_no | output | 1 | Interrupt, active low |

## Verification
The bench sweeps all 256 status byte values. For each value it checks the status bit and the interrupt, which separates the nibble position and the 1 to 8 window from the out-of-range codes 9 to 15. The running expected count then confirms that the accumulated total equals the arithmetic sum of the decoded values. Further patterns target specific behaviours:
- a byte presented without its strobe;
- events that coincide with a status read or a counter read;
- reads of the higher bytes after the count has moved on, which show that the snapshot is coherent;
- a second instance with a narrow counter, driven past its full value to show saturation.

// File: rtl/path_rei_pkg.sv
`timescale 1ns/1ps
package path_rei_pkg;
  localparam int FIELD_W  = 4;
  localparam int MAX_ERR  = 8;
  localparam int N_STS    = 7;
  localparam int REI_BIT  = 6;
  localparam int ADDR_W   = 3;
  localparam int A_STS    = 0;
  localparam int A_CNT0   = 1;
endpackage

// File: rtl/rei_decode.sv
`timescale 1ns/1ps
module rei_decode
  import path_rei_pkg::*;
(
  input  logic               stb_i,
  input  logic [7:0]         byte_i,
  output logic [FIELD_W-1:0] val_o,
  output logic               evt_o
);
  logic [FIELD_W-1:0] field;
  assign field = byte_i[7:8-FIELD_W];
  // codes above MAX_ERR are treated as zero errors
  assign val_o = (stb_i && field <= FIELD_W'(MAX_ERR)) ? field : '0;
  assign evt_o = |val_o;
endmodule

// File: rtl/rei_counter.sv
`timescale 1ns/1ps
module rei_counter
  import path_rei_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FIELD_W-1:0] inc_i,
  input  logic               clr_i,
  output logic [CNT_W-1:0]   cnt_o
);
  logic [CNT_W-1:0] cnt_q, base;
  logic [CNT_W:0]   sum;

  assign base = clr_i ? '0 : cnt_q;
  assign sum  = {1'b0, base} + (CNT_W+1)'(inc_i);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];

  assign cnt_o = cnt_q;

  a_r3_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> cnt_q >= $past(cnt_q));
  a_r3_sat_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '1 && !clr_i) |=> cnt_q == '1);
  a_r3_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i == '0 && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/rei_irq_status.sv
`timescale 1ns/1ps
module rei_irq_status
  import path_rei_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_STS-1:0] set_i,
  input  logic             clr_i,
  input  logic [N_STS-1:0] en_i,
  output logic [N_STS-1:0] sts_o,
  output logic             int_no
);
  logic [N_STS-1:0] sts_q;

  // set wins over clear-on-read
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= (clr_i ? '0 : sts_q) | set_i;

  assign sts_o  = sts_q;
  assign int_no = ~|(sts_q & en_i);

  a_r5_set_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((sts_q & $past(set_i)) == $past(set_i)));
  a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && set_i == '0) |=> sts_q == '0);
endmodule

// File: rtl/path_rei_monitor.sv
`timescale 1ns/1ps
module path_rei_monitor
  import path_rei_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              g1_stb_i,
  input  logic [7:0]        g1_byte_i,
  input  logic [5:0]        path_evt_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  input  logic [N_STS-1:0]  int_en_i,
  output logic              int_no
);
  localparam int N_BYTES = CNT_W / 8;

  logic [FIELD_W-1:0] err_val;
  logic               err_evt;
  logic [CNT_W-1:0]   cnt, snap_q;
  logic [N_STS-1:0]   sts, sts_set;
  logic               sts_rd, cnt_rd;
  logic [7:0]         rd_nxt;
  logic [7:0]         byte_sel [N_BYTES];

  assign sts_rd  = rd_en_i && 32'(rd_addr_i) == A_STS;
  assign cnt_rd  = rd_en_i && 32'(rd_addr_i) == A_CNT0;
  assign sts_set = {err_evt, path_evt_i};

  rei_decode u_dec (
    .stb_i (g1_stb_i), .byte_i (g1_byte_i), .val_o (err_val), .evt_o (err_evt)
  );

  rei_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .inc_i (err_val), .clr_i (cnt_rd), .cnt_o (cnt)
  );

  rei_irq_status u_sts (
    .clk_i, .rst_ni, .set_i (sts_set), .clr_i (sts_rd), .en_i (int_en_i),
    .sts_o (sts), .int_no
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     snap_q <= '0;
    else if (cnt_rd) snap_q <= cnt;

  for (genvar i = 0; i < N_BYTES; i++) begin : g_byte
    if (i == 0) begin : g_live
      assign byte_sel[i] = cnt[7:0];
    end else begin : g_snap
      assign byte_sel[i] = snap_q[8*i +: 8];
    end
  end

  always_comb begin
    rd_nxt = '0;
    if (sts_rd) rd_nxt = {1'b0, sts};
    for (int i = 0; i < N_BYTES; i++)
      if (32'(rd_addr_i) == A_CNT0 + i) rd_nxt = byte_sel[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= rd_nxt;

  a_r4_bit7_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_rd |=> !rd_data_o[7]);
  a_r7_clear_keeps_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_rd |=> cnt <= CNT_W'(MAX_ERR));
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
  a_r2_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (g1_stb_i && g1_byte_i[7:4] != 4'd0 && g1_byte_i[7:4] <= 4'd8) |=> sts[REI_BIT]);
endmodule

// File: tb/sim_path_rei_monitor.sv
`timescale 1ns/1ps
module sim_path_rei_monitor;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stb = 1'b0, stb1 = 1'b0;
  logic [7:0] g1 = '0;
  logic [5:0] pevt = '0;
  logic       rd_en = 1'b0, rd_en1 = 1'b0;
  logic [2:0] addr = '0;
  logic [6:0] en = '0;
  logic [7:0] rd_data, rd_data1;
  logic       irq_n, irq1_n;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  path_rei_monitor u0 (
    .clk_i(clk), .rst_ni(rst_n), .g1_stb_i(stb), .g1_byte_i(g1), .path_evt_i(pevt),
    .rd_en_i(rd_en), .rd_addr_i(addr), .rd_data_o(rd_data), .int_en_i(en), .int_no(irq_n)
  );

  path_rei_monitor #(.CNT_W(8)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .g1_stb_i(stb1), .g1_byte_i(g1), .path_evt_i(6'd0),
    .rd_en_i(rd_en1), .rd_addr_i(addr), .rd_data_o(rd_data1), .int_en_i(7'd0), .int_no(irq1_n)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic strobe(logic [7:0] b);
    @(negedge clk); stb = 1'b1; g1 = b;
    @(negedge clk); stb = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  function automatic int dec(logic [7:0] b);
    return (b[7:4] >= 1 && b[7:4] <= 8) ? int'(b[7:4]) : 0;
  endfunction

  initial begin
    #750000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    if (!done) $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int exp_cnt;
    exp_cnt = 0;
    #12 rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 int_no", irq_n, 1);
    chk("R9 rd_data", rd_data, 0);
    rd(3'd0, d); chk("R9 status", d, 0);
    rd(3'd1, d); chk("R9 count", d, 0);

    // R1 R2 R8 sweep of every status byte
    en = 7'h40;
    for (int v = 0; v < 256; v++) begin
      strobe(8'(v));
      exp_cnt += dec(8'(v));
      chk("R8 int_no sweep", irq_n, dec(8'(v)) != 0 ? 0 : 1);
      rd(3'd0, d);
      chk("R2 status bit6 sweep", d, dec(8'(v)) != 0 ? 8'h40 : 8'h00);
    end
    chk("R5 int_no after read", irq_n, 1);

    // R3 R6 accumulated count and snapshot coherency
    rd(3'd1, d); chk("R6 byte0", d, exp_cnt & 8'hff);
    strobe(8'h80); strobe(8'h80);
    rd(3'd2, d); chk("R6 byte1 snapshot", d, (exp_cnt >> 8) & 8'hff);
    rd(3'd3, d); chk("R6 byte2 snapshot", d, (exp_cnt >> 16) & 8'hff);
    rd(3'd4, d); chk("R6 byte3 snapshot", d, (exp_cnt >> 24) & 8'hff);
    rd(3'd5, d); chk("R6 unmapped", d, 0);
    // R7 live cleared by read, then only new increments
    rd(3'd1, d); chk("R7 after clear", d, 16);
    rd(3'd2, d); chk("R6 snapshot byte1 of 16", d, 0);
    rd(3'd0, d); // drop pending event

    // R1 byte without strobe ignored
    @(negedge clk); g1 = 8'h50;
    @(negedge clk); g1 = 8'h00;
    rd(3'd0, d); chk("R1 no strobe status", d, 0);
    rd(3'd1, d); chk("R1 no strobe count", d, 0);

    // R7 increment in same cycle as count read
    @(negedge clk); stb = 1'b1; g1 = 8'h30; rd_en = 1'b1; addr = 3'd1;
    @(negedge clk); stb = 1'b0; rd_en = 1'b0; d = rd_data;
    chk("R7 old value returned", d, 0);
    rd(3'd1, d); chk("R7 same-cycle increment kept", d, 3);

    // R5 event in same cycle as status read
    @(negedge clk); stb = 1'b1; g1 = 8'h10; rd_en = 1'b1; addr = 3'd0;
    @(negedge clk); stb = 1'b0; rd_en = 1'b0; d = rd_data;
    chk("R5 read before event", d, 8'h40);
    rd(3'd0, d); chk("R5 event survives read", d, 8'h40);
    rd(3'd0, d); chk("R5 cleared", d, 0);

    // R4 R8 other event bits, enables off then on
    for (int k = 0; k < 6; k++) begin
      en = 7'h00;
      @(negedge clk); pevt = 6'(1 << k);
      @(negedge clk); pevt = '0;
      chk("R8 disabled no irq", irq_n, 1);
      en = 7'(1 << k);
      #1 chk("R8 enabled irq", irq_n, 0);
      rd(3'd0, d); chk("R4 event bit position", d, 8'(1 << k));
    end
    en = 7'h7f;
    @(negedge clk); pevt = 6'h3f;
    @(negedge clk); pevt = '0;
    strobe(8'h20);
    rd(3'd0, d); chk("R4 all bits bit7 zero", d, 8'h7f);

    // R10 hold without read
    repeat (3) @(negedge clk);
    chk("R10 rd_data held", rd_data, 8'h7f);

    // R3 saturation on narrow counter
    for (int i = 0; i < 33; i++) begin
      @(negedge clk); stb1 = 1'b1; g1 = (i == 32) ? 8'h10 : 8'h80;
      @(negedge clk); stb1 = 1'b0;
    end
    @(negedge clk); rd_en1 = 1'b1; addr = 3'd1;
    @(negedge clk); rd_en1 = 1'b0;
    chk("R3 saturated", rd_data1, 8'hff);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule